// File: doc/BRIEF.md
# Channel Status Bit Assembler

This block supplies the channel-status (C) bit for every subframe of a two-channel digital audio interface transmitter. A 192-frame block carries one C bit per channel per frame, so there are two 192-bit status blocks, one for the left channel and one for the right. For each subframe strobe the block works out the bit position in the status block and takes a serial C input. It ORs that input with a value from a small set of active-low configuration pins. The meaning of those pins depends on whether professional or consumer format is selected. In professional format the last eight positions of each block carry a CRC that the block computes itself.

A pass-through setting lets status data received elsewhere be forwarded unchanged. In that setting the configuration pins are ignored and the serial C bit goes out as it is. Block alignment is then slaved to an external block-sync line, which is sampled on left subframes. A low sample followed by a high sample restarts the block. A block-window output goes high for the first 128 frames of each block, so upstream logic can line up its serial C, U and V data with the block.

Top module: `cs_status_asm`

## Requirements
- R1: Each left/right strobe pair forms one frame. The frame index starts at 0 after reset and advances after each right strobe. It wraps from 191 to 0. Both subframes of a frame use the same index.
- R2: Outside pass-through, bit 0 is forced to 1 when `cons_sel`=0 (professional) and is not forced when `cons_sel`=1 (consumer), in both channels.
- R3: In professional format, `ded_n[0]`, `ded_n[1]`, `ded_n[2]` and `ded_n[3]` drive bits 1, 6, 7 and 9 as inverses. `ded_n[4]` is unused. `sel_pair` gives bits {4,3,2}: 00→111, 01→011, 10→000, 11→001.
- R4: In consumer format, `ded_n[0..4]` drive bits 2, 3, 8, 9 and 15 as inverses. `sel_pair` gives bits {25,24}: 00→00, 01→10, 10→11, 11→00.
- R5: With `cons_sel`=1 and `sel_pair`=11 (CD submode) outside pass-through, `c_ser` has no effect on `c_bit` and `blk_mark` stays 0.
- R6: Outside the CD submode, `c_ser` is ORed into the emitted bit at every position, including positions driven by pins or by the CRC.
- R7: In professional format, bit 184+k carries bit k of a CRC, for k=0..7. The CRC uses the polynomial x^8+x^4+x^3+x^2+1. The register is preset to all ones at bit 0. For each emitted bit d at positions 0..183, the register shifts left, and the polynomial (0x1D) is XORed in when (crc[7] xor d) is 1. Each channel has its own CRC.
- R8: With `pass_thru`=1, `c_bit` equals `c_ser` of the same strobe. Pins, format select and CRC have no effect.
- R9: With `pass_thru`=1, `blk_sync_in` is sampled on each left strobe. When the previous sample was 0 and the current one is 1, the current frame becomes index 0. The previous sample resets to 1.
- R10: `blk_mark` is high for frames 0..127 and low for frames 128..191. In pass-through it follows the recovered alignment.
- R11: `c_vld`, `c_bit`, `c_right` and `blk_mark` are registered. They are updated in the cycle after `sf_stb`, and `c_vld` is high for that one cycle only. All outputs are 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_stb | input | 1 | One-cycle strobe per subframe |
| sf_right | input | 1 | Subframe channel: 0 left, 1 right |
| c_ser | input | 1 | Serial channel-status bit for this subframe |
| cons_sel | input | 1 | 0 professional, 1 consumer |
| ded_n | input | 5 | Active-low dedicated status pins |
| sel_pair | input | 2 | Emphasis code (professional) or frequency code (consumer) |
| pass_thru | input | 1 | Pass-through setting |
| blk_sync_in | input | 1 | External block-start level, used in pass-through |
| c_vld | output | 1 | Result strobe |
| c_bit | output | 1 | Assembled channel-status bit |
| c_right | output | 1 | Channel of the result |
| blk_mark | output | 1 | High during frames 0..127 of the block |

## Verification
Every result is due exactly one clock after its strobe, because one register stage sits between the inputs and the outputs. The driver task pushes the expected bit, channel and window flag into a queue when it raises the strobe. The monitor then pops and compares on the falling edge that follows the next rising edge, which is the first edge where `c_vld` is high. Alignment and CRC values come from a frame index and CRC model kept in the bench. Each strobe is followed by an idle cycle, so results never overlap.

// File: rtl/cs_asm_pkg.sv
package cs_asm_pkg;

   // professional emphasis code -> {bit4, bit3, bit2}
   function automatic logic [2:0] emph_bits(input logic [1:0] code);
      case (code)
         2'b00:   emph_bits = 3'b111;
         2'b01:   emph_bits = 3'b011;
         2'b10:   emph_bits = 3'b000;
         default: emph_bits = 3'b001;
      endcase
   endfunction

   // consumer frequency code -> {bit25, bit24}
   function automatic logic [1:0] freq_bits(input logic [1:0] code);
      case (code)
         2'b00:   freq_bits = 2'b00;
         2'b01:   freq_bits = 2'b10;
         2'b10:   freq_bits = 2'b11;
         default: freq_bits = 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/cs_frame_ctr.sv
module cs_frame_ctr #(
   parameter int unsigned BLOCK_LEN = 192,
   parameter int unsigned IDX_W     = $clog2(BLOCK_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sf_stb,
   input  logic             sf_right,
   input  logic             pass_thru,
   input  logic             blk_sync_in,
   output logic [IDX_W-1:0] idx_now
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(BLOCK_LEN - 1);

   logic [IDX_W-1:0] idx_q;
   logic             sync_q;
   logic             left_stb;
   logic             sync_rise;

   assign left_stb  = sf_stb && !sf_right;
   assign sync_rise = left_stb && pass_thru && !sync_q && blk_sync_in;
   assign idx_now   = sync_rise ? '0 : idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         sync_q <= 1'b1;
      end else begin
         if (sf_stb) begin
            if (sf_right) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
            else          idx_q <= idx_now;
         end
         if (left_stb && pass_thru) sync_q <= blk_sync_in;
      end
   end

   p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST);

   p_right_adv_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_stb && sf_right && idx_q != LAST) |=> idx_q == $past(idx_q) + 1'b1);

   p_sync_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (left_stb && pass_thru && !sync_q && blk_sync_in) |=> idx_q == '0);

endmodule

// File: rtl/cs_crc_chan.sv
module cs_crc_chan #(
   parameter int unsigned      CRC_W = 8,
   parameter logic [CRC_W-1:0] POLY  = 8'h1D,
   parameter logic [CRC_W-1:0] INIT  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic             restart,
   input  logic             d_in,
   output logic [CRC_W-1:0] crc_q
);
   logic [CRC_W-1:0] base;
   logic             fb;

   assign base = restart ? INIT : crc_q;
   assign fb   = base[CRC_W-1] ^ d_in;

   always_ff @(posedge clk) begin
      if (!rst_n)   crc_q <= INIT;
      else if (upd) crc_q <= {base[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   p_crc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(crc_q));

endmodule

// File: rtl/cs_bit_map.sv
module cs_bit_map
   import cs_asm_pkg::*;
#(
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned CRC_W   = 8,
   parameter int unsigned CRC_POS = 184
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             cons_sel,
   input  logic [4:0]       ded_n,
   input  logic [1:0]       sel_pair,
   input  logic [CRC_W-1:0] crc_val,
   output logic             pin_bit
);
   localparam int unsigned SEL_W = (CRC_W > 1) ? $clog2(CRC_W) : 1;

   logic [2:0]       emph;
   logic [1:0]       freq;
   logic [IDX_W-1:0] off;

   assign emph = emph_bits(sel_pair);
   assign freq = freq_bits(sel_pair);
   assign off  = idx - IDX_W'(CRC_POS);

   always_comb begin
      pin_bit = 1'b0;
      if (!cons_sel) begin
         if (idx >= IDX_W'(CRC_POS)) pin_bit = crc_val[off[SEL_W-1:0]];
         else begin
            case (idx)
               IDX_W'(0): pin_bit = 1'b1;
               IDX_W'(1): pin_bit = ~ded_n[0];
               IDX_W'(2): pin_bit = emph[0];
               IDX_W'(3): pin_bit = emph[1];
               IDX_W'(4): pin_bit = emph[2];
               IDX_W'(6): pin_bit = ~ded_n[1];
               IDX_W'(7): pin_bit = ~ded_n[2];
               IDX_W'(9): pin_bit = ~ded_n[3];
               default:   pin_bit = 1'b0;
            endcase
         end
      end else begin
         case (idx)
            IDX_W'(2):  pin_bit = ~ded_n[0];
            IDX_W'(3):  pin_bit = ~ded_n[1];
            IDX_W'(8):  pin_bit = ~ded_n[2];
            IDX_W'(9):  pin_bit = ~ded_n[3];
            IDX_W'(15): pin_bit = ~ded_n[4];
            IDX_W'(24): pin_bit = freq[0];
            IDX_W'(25): pin_bit = freq[1];
            default:    pin_bit = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/cs_status_asm.sv
module cs_status_asm #(
   parameter int unsigned      BLOCK_LEN = 192,
   parameter int unsigned      MARK_LEN  = 128,
   parameter int unsigned      CRC_W     = 8,
   parameter logic [CRC_W-1:0] CRC_POLY  = 8'h1D,
   parameter logic [CRC_W-1:0] CRC_INIT  = '1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sf_stb,
   input  logic       sf_right,
   input  logic       c_ser,
   input  logic       cons_sel,
   input  logic [4:0] ded_n,
   input  logic [1:0] sel_pair,
   input  logic       pass_thru,
   input  logic       blk_sync_in,
   output logic       c_vld,
   output logic       c_bit,
   output logic       c_right,
   output logic       blk_mark
);
   localparam int unsigned IDX_W   = $clog2(BLOCK_LEN);
   localparam int unsigned CRC_POS = BLOCK_LEN - CRC_W;

   if (MARK_LEN > BLOCK_LEN) begin : g_bad_mark
      $error("MARK_LEN must not exceed BLOCK_LEN");
   end
   if (CRC_W < 2 || CRC_W >= BLOCK_LEN) begin : g_bad_crc
      $error("CRC_W out of range");
   end

   logic [IDX_W-1:0] idx_now;
   logic [CRC_W-1:0] crc_vals [2];
   logic [CRC_W-1:0] crc_sel;
   logic             pin_bit;
   logic             cd_mode;
   logic             tx_bit;

   cs_frame_ctr #(.BLOCK_LEN(BLOCK_LEN), .IDX_W(IDX_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .sf_stb(sf_stb), .sf_right(sf_right),
      .pass_thru(pass_thru), .blk_sync_in(blk_sync_in), .idx_now(idx_now)
   );

   for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      cs_crc_chan #(.CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
         .clk(clk), .rst_n(rst_n),
         .upd(sf_stb && (sf_right == 1'(ch)) && idx_now < IDX_W'(CRC_POS)),
         .restart(idx_now == '0),
         .d_in(tx_bit),
         .crc_q(crc_vals[ch])
      );
   end

   assign crc_sel = sf_right ? crc_vals[1] : crc_vals[0];

   cs_bit_map #(.IDX_W(IDX_W), .CRC_W(CRC_W), .CRC_POS(CRC_POS)) u_map (
      .idx(idx_now), .cons_sel(cons_sel), .ded_n(ded_n),
      .sel_pair(sel_pair), .crc_val(crc_sel), .pin_bit(pin_bit)
   );

   assign cd_mode = !pass_thru && cons_sel && (sel_pair == 2'b11);
   assign tx_bit  = pass_thru ? c_ser : ((c_ser && !cd_mode) || pin_bit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_vld    <= 1'b0;
         c_bit    <= 1'b0;
         c_right  <= 1'b0;
         blk_mark <= 1'b0;
      end else begin
         c_vld <= sf_stb;
         if (sf_stb) begin
            c_bit    <= tx_bit;
            c_right  <= sf_right;
            blk_mark <= !cd_mode && (idx_now < IDX_W'(MARK_LEN));
         end
      end
   end

   p_vld_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
      c_vld |-> $past(sf_stb));

   p_cd_nomark_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (c_vld && $past(!pass_thru && cons_sel && sel_pair == 2'b11)) |-> !blk_mark);

   p_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (c_vld && $past(pass_thru)) |-> c_bit == $past(c_ser));

   p_pro_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (c_vld && $past(!pass_thru && !cons_sel && idx_now == '0)) |-> c_bit);

   p_ser_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (c_vld && $past(!cd_mode && c_ser)) |-> c_bit);

endmodule

// File: tb/sim_cs_status_asm.sv
module sim_cs_status_asm;
   typedef struct packed {
      logic bit_v;
      logic right;
      logic mark;
      int   idx;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sf_stb = 1'b0, sf_right = 1'b0, c_ser = 1'b0;
   logic       cons_sel = 1'b0, pass_thru = 1'b0, blk_sync_in = 1'b0;
   logic [4:0] ded_n = 5'b11111;
   logic [1:0] sel_pair = 2'b00;
   logic       c_vld, c_bit, c_right, blk_mark;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   exp_t q[$];

   int         m_idx;
   logic       m_sync;
   logic [7:0] m_crc [2];
   logic [7:0] lfsr = 8'hA5;

   always #2 clk = ~clk;

   cs_status_asm u0 (
      .clk(clk), .rst_n(rst_n), .sf_stb(sf_stb), .sf_right(sf_right),
      .c_ser(c_ser), .cons_sel(cons_sel), .ded_n(ded_n), .sel_pair(sel_pair),
      .pass_thru(pass_thru), .blk_sync_in(blk_sync_in),
      .c_vld(c_vld), .c_bit(c_bit), .c_right(c_right), .blk_mark(blk_mark)
   );

   // watchdog
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_cmp++; n_bad++;
         $display("FAIL R11 watchdog expired: actual hung, expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   // monitor
   always @(negedge clk) begin
      if (rst_n && c_vld) begin
         exp_t e;
         if (q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R11 unexpected result: actual c_vld=1, expected 0");
         end else begin
            e = q.pop_front();
            n_cmp++;
            if (c_bit !== e.bit_v || c_right !== e.right || blk_mark !== e.mark) begin
               n_bad++;
               $display("FAIL R1-map idx=%0d (R2 R3 R4 R5 R6 R7 R8 R9 R10): actual bit=%b ch=%b mark=%b, expected bit=%b ch=%b mark=%b",
                        e.idx, c_bit, c_right, blk_mark, e.bit_v, e.right, e.mark);
            end
         end
      end
   end

   function automatic logic [2:0] m_emph(input logic [1:0] c);
      case (c) 2'b00: return 3'b111; 2'b01: return 3'b011;
               2'b10: return 3'b000; default: return 3'b001; endcase
   endfunction

   function automatic logic [1:0] m_freq(input logic [1:0] c);
      case (c) 2'b01: return 2'b10; 2'b10: return 2'b11; default: return 2'b00; endcase
   endfunction

   function automatic logic pin_val(input int i, input logic [7:0] crc);
      logic [2:0] em;
      logic [1:0] fq;
      em = m_emph(sel_pair);
      fq = m_freq(sel_pair);
      if (!cons_sel) begin  // R2 R3 R7
         if (i >= 184) return crc[i-184];
         if (i == 0) return 1'b1;
         if (i == 1) return ~ded_n[0];
         if (i >= 2 && i <= 4) return em[i-2];
         if (i == 6) return ~ded_n[1];
         if (i == 7) return ~ded_n[2];
         if (i == 9) return ~ded_n[3];
         return 1'b0;
      end
      // R4
      if (i == 2) return ~ded_n[0];
      if (i == 3) return ~ded_n[1];
      if (i == 8) return ~ded_n[2];
      if (i == 9) return ~ded_n[3];
      if (i == 15) return ~ded_n[4];
      if (i == 24) return fq[0];
      if (i == 25) return fq[1];
      return 1'b0;
   endfunction

   task automatic send(input logic right, input logic c);
      exp_t e;
      logic cd, b;
      logic [7:0] base;
      int ch;
      ch = right ? 1 : 0;
      if (!right && pass_thru) begin  // R9
         if (!m_sync && blk_sync_in) m_idx = 0;
         m_sync = blk_sync_in;
      end
      cd = !pass_thru && cons_sel && sel_pair == 2'b11;
      if (pass_thru) b = c;                                   // R8
      else b = (c && !cd) || pin_val(m_idx, m_crc[ch]);       // R5 R6
      if (m_idx < 184) begin                                  // R7
         base = (m_idx == 0) ? 8'hFF : m_crc[ch];
         m_crc[ch] = {base[6:0], 1'b0} ^ ((base[7] ^ b) ? 8'h1D : 8'h00);
      end
      e.bit_v = b; e.right = right; e.mark = !cd && m_idx < 128; e.idx = m_idx; // R10
      @(negedge clk);
      sf_stb = 1'b1; sf_right = right; c_ser = c;
      q.push_back(e);
      @(negedge clk);
      sf_stb = 1'b0;
      if (right) m_idx = (m_idx == 191) ? 0 : m_idx + 1;      // R1
   endtask

   task automatic send_frame(input logic cl, input logic cr);
      send(1'b0, cl);
      send(1'b1, cr);
   endtask

   function automatic logic nxt();
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      return lfsr[0];
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      n_cmp++;  // R11 reset state
      if (c_vld !== 1'b0 || c_bit !== 1'b0 || blk_mark !== 1'b0 || c_right !== 1'b0) begin
         n_bad++;
         $display("FAIL R11 reset: actual vld=%b bit=%b mark=%b ch=%b, expected 0 0 0 0",
                  c_vld, c_bit, blk_mark, c_right);
      end
      m_idx = 0; m_sync = 1'b1; m_crc[0] = 8'hFF; m_crc[1] = 8'hFF;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      // T1: professional, static pins, serial 1 on bit 5 left (R1 R2 R3 R6 R7 R10)
      cons_sel = 1'b0; ded_n = 5'b10110; sel_pair = 2'b01;
      do_reset();
      for (int f = 0; f < 194; f++) send_frame(f == 5, 1'b0);

      // T2: professional, random serial data incl. CRC region (R6 R7)
      sel_pair = 2'b11; ded_n = 5'b01001;
      do_reset();
      for (int f = 0; f < 192; f++) send_frame(nxt(), nxt());

      // T3: consumer, 32 kHz code (R2 R4)
      cons_sel = 1'b1; sel_pair = 2'b10; ded_n = 5'b01010;
      do_reset();
      for (int f = 0; f < 192; f++) send_frame(1'b0, f == 40);

      // T4: consumer CD submode, serial held high (R5)
      sel_pair = 2'b11; ded_n = 5'b11111;
      do_reset();
      for (int f = 0; f < 30; f++) send_frame(1'b1, 1'b1);

      // T5: pass-through with external alignment (R8 R9 R10)
      cons_sel = 1'b0; ded_n = 5'b00000; sel_pair = 2'b00; pass_thru = 1'b1;
      blk_sync_in = 1'b1;
      do_reset();
      for (int f = 0; f < 30; f++) begin
         blk_sync_in = (f < 3) ? 1'b1 : 1'b0;  // held high from reset: no restart
         send_frame(nxt(), nxt());
      end
      for (int f = 0; f < 140; f++) begin
         blk_sync_in = (f < 6) ? 1'b1 : 1'b0;  // one rise at f=0
         send_frame(nxt(), nxt());
      end
      for (int f = 0; f < 20; f++) begin
         blk_sync_in = (f >= 10 && f < 12);    // second rise realigns mid-block
         send_frame(nxt(), nxt());
      end
      pass_thru = 1'b0;

      repeat (4) @(negedge clk);
      n_cmp++;  // R11 every strobe produced exactly one result
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R11 pending results: actual %0d, expected 0", q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule